// File: doc/BRIEF.md
# Audio Codec Sample Data Port

This block carries audio samples between a processor or DMA engine and the codec side of an audio controller. Samples arriving from the codec on a valid-only stream are held in a receive FIFO. Software or DMA drains that FIFO through a read-data register. In the other direction, software or DMA fills a transmit FIFO through a write-data register. Once the transmit FIFO reaches either its capacity or the free space the codec reports, it is flushed to the codec over a valid/ready stream.

A control register gates the path. It also enables each DMA request line on its own and drives the interrupt line directly. A transfer-status register holds software bits and adds live FIFO flags when read. Samples are always 16 bits wide, and each FIFO holds 1024 entries by default. When the path loses its enable, both FIFOs, the flush state and the overflow flag are cleared.

Register addresses on `reg_addr_i`: 0 is control, 1 is transfer status, 2 is read data, 3 is write data.

Top module: `codec_sample_port`

## Requirements
- R1: The path is enabled only when control bit 0 is 0, control bit 1 is 1 and `hw_en_i` is 1. While the path is disabled, codec samples and write-data writes are not accepted.
- R2: `rx_drq_o` is 1 when the path is enabled, control bit 12 is set and the receive FIFO holds at least one sample.
- R3: `tx_drq_o` is 1 when the path is enabled, control bit 11 is set and the transmit fill count is below `tx_free_i`.
- R4: `irq_o` equals control bit 14.
- R5: Reading address 1 returns the stored software bits in [7:0]. Bit 7 is ORed with "receive FIFO not empty" and bit 5 with "transmit fill count below `tx_free_i`". Writes to address 1 keep only the bits under mask 0x5F. The reset value is 0.
- R6: Reading address 2 pops the oldest received sample and returns it. When the receive FIFO is empty, the read returns 0 and nothing changes.
- R7: Each write to address 3 appends one sample. If the fill count after the write equals the capacity or `tx_free_i`, with `tx_free_i` non-zero, the FIFO drains in order on `tx_valid_o`/`tx_ready_i` until it is empty.
- R8: If the fill count reaches capacity while `tx_free_i` is 0, the whole transmit FIFO is discarded.
- R9: A write to address 2 has no effect. A read of address 3 returns 0.
- R10: A push and a pop in the same cycle leave the count unchanged and keep FIFO order.
- R11: Disabling the path empties both FIFOs and clears the flush state and the overflow flag on the next clock edge.
- R12: A codec sample that arrives while the receive FIFO is full is dropped, and `rx_ovf_o` is set. The flag stays set until the path is disabled or reset.
- R13: The control register (address 0) resets to 0 and keeps only the bits under mask 0x780F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hw_en_i | input | 1 | External hardware enable |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (pops on address 2) |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Register read data, combinational |
| rx_valid_i | input | 1 | Codec sample valid |
| rx_data_i | input | DW | Codec sample |
| tx_valid_o | output | 1 | Sample to codec valid |
| tx_data_o | output | DW | Sample to codec |
| tx_ready_i | input | 1 | Codec accepts sample |
| tx_free_i | input | CNT_W | Free sample slots downstream |
| rx_drq_o | output | 1 | Receive DMA request |
| tx_drq_o | output | 1 | Transmit DMA request |
| irq_o | output | 1 | Interrupt |
| rx_ovf_o | output | 1 | Sticky receive overflow |

## Verification
A wrong count or pointer shows up one cycle later as a DMA request that is off or on when it should not be. It also shows up as a wrong status bit 7 or 5, or as a sample that comes out of order on the next read-data access or the next `tx_data_o` beat. A missed or spurious flush shows up in the cycle after the triggering write, when `tx_valid_o` fails to rise or rises when it should not. Because the reference model is compared with every output on every clock, any of these divergences is caught in the first cycle it becomes visible.

// File: rtl/codec_port_pkg.sv
package codec_port_pkg;
  localparam logic [1:0] ADR_CTRL  = 2'd0;
  localparam logic [1:0] ADR_STAT  = 2'd1;
  localparam logic [1:0] ADR_RDATA = 2'd2;
  localparam logic [1:0] ADR_WDATA = 2'd3;

  localparam logic [15:0] CTRL_MASK = 16'h780F;
  localparam logic [7:0]  STAT_MASK = 8'h5F;

  localparam int unsigned BIT_PWD   = 0;
  localparam int unsigned BIT_AEN   = 1;
  localparam int unsigned BIT_WDMA  = 11;
  localparam int unsigned BIT_RDMA  = 12;
  localparam int unsigned BIT_IRQ   = 14;
  localparam int unsigned STAT_RXAV = 7;
  localparam int unsigned STAT_TXSP = 5;
endpackage

// File: rtl/sample_fifo.sv
module sample_fifo #(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned DW    = 16,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [DW-1:0]    data_i,
  output logic [DW-1:0]    head_o,
  output logic [CNT_W-1:0] count_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0]    mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_i && !clr_i) mem[wr_ptr] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + AW'(1);
      if (pop_i)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + AW'(1);
      cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end

  assign head_o  = mem[rd_ptr];
  assign count_o = cnt_q;
endmodule

// File: rtl/codec_port_regs.sv
module codec_port_regs
  import codec_port_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [15:0]   ctrl_o,
  output logic [7:0]    stat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= '0;
      stat_o <= '0;
    end else if (we_i) begin
      if (addr_i == ADR_CTRL) ctrl_o <= wdata_i[15:0] & CTRL_MASK;
      if (addr_i == ADR_STAT) stat_o <= wdata_i[7:0] & STAT_MASK;
    end
  end
endmodule

// File: rtl/tx_flush_ctrl.sv
module tx_flush_ctrl #(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             path_en_i,
  input  logic             push_i,
  input  logic             tx_ready_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] free_i,
  output logic             pop_o,
  output logic             clr_o,
  output logic             valid_o
);
  localparam logic [CNT_W:0] FULL_W = (CNT_W + 1)'(DEPTH);

  logic            drain_q;
  logic [CNT_W:0]  cnt_nxt;
  logic            trig, discard;

  assign pop_o   = drain_q && tx_ready_i && (cnt_i != '0);
  assign cnt_nxt = {1'b0, cnt_i} + (CNT_W + 1)'(push_i) - (CNT_W + 1)'(pop_o);
  // flush once the fill hits capacity or the downstream free space
  assign trig    = push_i && ((cnt_nxt == FULL_W) || (cnt_nxt == {1'b0, free_i}));
  assign discard = trig && (free_i == '0);
  assign clr_o   = !path_en_i || discard;
  assign valid_o = drain_q && (cnt_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     drain_q <= 1'b0;
    else if (!path_en_i || discard)  drain_q <= 1'b0;
    else if (trig)                   drain_q <= 1'b1;
    else if (cnt_nxt == '0)          drain_q <= 1'b0;
  end
endmodule

// File: rtl/codec_sample_port.sv
module codec_sample_port
  import codec_port_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned DW    = 16,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hw_en_i,
  input  logic             reg_we_i,
  input  logic             reg_re_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  input  logic             rx_valid_i,
  input  logic [DW-1:0]    rx_data_i,
  output logic             tx_valid_o,
  output logic [DW-1:0]    tx_data_o,
  input  logic             tx_ready_i,
  input  logic [CNT_W-1:0] tx_free_i,
  output logic             rx_drq_o,
  output logic             tx_drq_o,
  output logic             irq_o,
  output logic             rx_ovf_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [15:0]      ctrl;
  logic [7:0]       stat;
  logic             path_en;
  logic [CNT_W-1:0] rx_cnt, tx_cnt;
  logic [DW-1:0]    rx_head;
  logic             rx_push, rx_pop, rx_full;
  logic             tx_push, tx_pop, tx_clr;
  logic             rx_av, tx_sp;
  logic             ovf_q;

  codec_port_regs #(.DW(DW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .ctrl_o  (ctrl),
    .stat_o  (stat)
  );

  assign path_en = !ctrl[BIT_PWD] && ctrl[BIT_AEN] && hw_en_i;

  assign rx_full = (rx_cnt == FULL);
  assign rx_push = path_en && rx_valid_i && !rx_full;
  assign rx_pop  = path_en && reg_re_i && (reg_addr_i == ADR_RDATA) && (rx_cnt != '0);

  sample_fifo #(.DEPTH(DEPTH), .DW(DW), .CNT_W(CNT_W)) u_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (!path_en),
    .push_i  (rx_push),
    .pop_i   (rx_pop),
    .data_i  (rx_data_i),
    .head_o  (rx_head),
    .count_o (rx_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      ovf_q <= 1'b0;
    else if (!path_en)                ovf_q <= 1'b0;
    else if (rx_valid_i && rx_full)   ovf_q <= 1'b1;
  end

  assign tx_push = path_en && reg_we_i && (reg_addr_i == ADR_WDATA) && (tx_cnt != FULL);

  tx_flush_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_flush (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .path_en_i  (path_en),
    .push_i     (tx_push),
    .tx_ready_i (tx_ready_i),
    .cnt_i      (tx_cnt),
    .free_i     (tx_free_i),
    .pop_o      (tx_pop),
    .clr_o      (tx_clr),
    .valid_o    (tx_valid_o)
  );

  sample_fifo #(.DEPTH(DEPTH), .DW(DW), .CNT_W(CNT_W)) u_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (tx_clr),
    .push_i  (tx_push),
    .pop_i   (tx_pop),
    .data_i  (reg_wdata_i),
    .head_o  (tx_data_o),
    .count_o (tx_cnt)
  );

  assign rx_av    = (rx_cnt != '0);
  assign tx_sp    = (tx_cnt < tx_free_i);
  assign rx_drq_o = path_en && ctrl[BIT_RDMA] && rx_av;
  assign tx_drq_o = path_en && ctrl[BIT_WDMA] && tx_sp;
  assign irq_o    = ctrl[BIT_IRQ];
  assign rx_ovf_o = ovf_q;

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      ADR_CTRL:  reg_rdata_o = DW'(ctrl);
      ADR_STAT: begin
        reg_rdata_o = DW'(stat);
        reg_rdata_o[STAT_RXAV] = stat[STAT_RXAV] | rx_av;
        reg_rdata_o[STAT_TXSP] = stat[STAT_TXSP] | tx_sp;
      end
      ADR_RDATA: reg_rdata_o = rx_av ? rx_head : '0;
      default:   reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/codec_sample_port_chk.sv
module codec_sample_port_chk
  import codec_port_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned DW    = 16,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_i,
  input logic             reg_re_i,
  input logic [1:0]       reg_addr_i,
  input logic             wr_irq_bit_i,
  input logic [DW-1:0]    reg_rdata_o,
  input logic             rx_valid_i,
  input logic             tx_ready_i,
  input logic             tx_valid_o,
  input logic [DW-1:0]    tx_data_o,
  input logic             irq_o,
  input logic             rx_drq_o,
  input logic             rx_ovf_o,
  input logic             path_en,
  input logic [CNT_W-1:0] rx_cnt,
  input logic [CNT_W-1:0] tx_cnt
);
  AST_IRQ_TRACKS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == ADR_CTRL) |=> (irq_o == $past(wr_irq_bit_i))); // R4

  AST_RX_DRQ_HAS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_drq_o |-> (path_en && rx_cnt != '0)); // R2

  AST_EMPTY_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == ADR_RDATA && rx_cnt == '0) |-> (reg_rdata_o == '0)); // R6

  AST_TX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i && path_en && !reg_we_i) |=>
      (!path_en || (tx_valid_o && $stable(tx_data_o)))); // R7

  AST_RDATA_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (path_en && reg_we_i && reg_addr_i == ADR_RDATA && !reg_re_i && !rx_valid_i) |=>
      (rx_cnt == $past(rx_cnt))); // R9

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_cnt <= CNT_W'(DEPTH)) && (tx_cnt <= CNT_W'(DEPTH))); // R10

  AST_OFF_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !path_en |=> (rx_cnt == '0 && tx_cnt == '0 && !rx_ovf_o)); // R11

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_ovf_o && path_en) |=> rx_ovf_o); // R12
endmodule

bind codec_sample_port codec_sample_port_chk #(.DEPTH(DEPTH), .DW(DW), .CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .reg_we_i     (reg_we_i),
  .reg_re_i     (reg_re_i),
  .reg_addr_i   (reg_addr_i),
  .wr_irq_bit_i (reg_wdata_i[14]),
  .reg_rdata_o  (reg_rdata_o),
  .rx_valid_i   (rx_valid_i),
  .tx_ready_i   (tx_ready_i),
  .tx_valid_o   (tx_valid_o),
  .tx_data_o    (tx_data_o),
  .irq_o        (irq_o),
  .rx_drq_o     (rx_drq_o),
  .rx_ovf_o     (rx_ovf_o),
  .path_en      (path_en),
  .rx_cnt       (rx_cnt),
  .tx_cnt       (tx_cnt)
);

// File: tb/sim_codec_sample_port.sv
`timescale 1ns/1ps
module sim_codec_sample_port;
  localparam int DEPTH = 1024;
  localparam int DW    = 16;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hw_en = 1'b0;
  logic reg_we = 1'b0, reg_re = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic rx_valid = 1'b0;
  logic [DW-1:0] rx_data = '0;
  logic tx_valid;
  logic [DW-1:0] tx_data;
  logic tx_ready = 1'b0;
  logic [CW-1:0] tx_free = '0;
  logic rx_drq, tx_drq, irq, rx_ovf;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  codec_sample_port #(.DEPTH(DEPTH), .DW(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .hw_en_i(hw_en),
    .reg_we_i(reg_we), .reg_re_i(reg_re), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_ready_i(tx_ready),
    .tx_free_i(tx_free), .rx_drq_o(rx_drq), .tx_drq_o(tx_drq),
    .irq_o(irq), .rx_ovf_o(rx_ovf)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model
  logic [15:0] m_ctrl;
  logic [7:0]  m_stat;
  bit m_drain, m_ovf;
  logic [15:0] rxq[$];
  logic [15:0] txq[$];

  function automatic bit m_en();
    return !m_ctrl[0] && m_ctrl[1] && hw_en;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = '0; m_stat = '0; m_drain = 0; m_ovf = 0;
      rxq.delete(); txq.delete();
    end else begin
      if (!m_en()) begin
        rxq.delete(); txq.delete(); m_drain = 0; m_ovf = 0;
      end else begin
        bit full_rx, push, pop, trig;
        int n;
        full_rx = (rxq.size() == DEPTH);
        if (reg_re && reg_addr == 2'd2 && rxq.size() > 0) void'(rxq.pop_front());
        if (rx_valid) begin
          if (full_rx) m_ovf = 1; else rxq.push_back(rx_data);
        end
        push = reg_we && reg_addr == 2'd3 && txq.size() < DEPTH;
        pop  = m_drain && tx_ready && txq.size() > 0;
        n = txq.size() + int'(push) - int'(pop);
        trig = push && (n == DEPTH || n == int'(tx_free));
        if (pop) void'(txq.pop_front());
        if (push) txq.push_back(reg_wdata);
        if (trig && tx_free == 0) begin txq.delete(); m_drain = 0; end
        else if (trig) m_drain = 1;
        else if (n == 0) m_drain = 0;
      end
      if (reg_we && reg_addr == 2'd0) m_ctrl = reg_wdata & 16'h780F;
      if (reg_we && reg_addr == 2'd1) m_stat = reg_wdata[7:0] & 8'h5F;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit en, ev;
      logic [15:0] er;
      string tag;
      en = m_en();
      chk(irq == m_ctrl[14], "R4", irq, m_ctrl[14]);
      ev = en && m_ctrl[12] && rxq.size() > 0;
      chk(rx_drq == ev, "R2", rx_drq, ev);
      ev = en && m_ctrl[11] && txq.size() < int'(tx_free);
      chk(tx_drq == ev, "R3", tx_drq, ev);
      ev = m_drain && txq.size() > 0;
      chk(tx_valid == ev, "R7", tx_valid, ev);
      if (ev) chk(tx_data == txq[0], "R7", tx_data, txq[0]);
      chk(rx_ovf == m_ovf, "R12", rx_ovf, m_ovf);
      case (reg_addr)
        2'd0: begin er = m_ctrl; tag = "R13"; end
        2'd1: begin
          er = {8'h0, m_stat};
          if (rxq.size() > 0) er[7] = 1'b1;
          if (txq.size() < int'(tx_free)) er[5] = 1'b1;
          tag = "R5";
        end
        2'd2: begin er = (rxq.size() > 0) ? rxq[0] : 16'h0; tag = "R6"; end
        default: begin er = 16'h0; tag = "R9"; end
      endcase
      chk(reg_rdata == er, tag, reg_rdata, er);
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #2;
    reg_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_re = 1; reg_addr = a;
    @(negedge clk); d = reg_rdata;
    @(posedge clk); #2;
    reg_re = 0;
  endtask

  task automatic rx_send(input logic [15:0] d);
    rx_valid = 1; rx_data = d;
    @(posedge clk); #2;
    rx_valid = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    tick();
    // reset state
    rd(2'd0, d); chk(d == 16'h0, "R13", d, 0);
    rd(2'd1, d); chk(d == 16'h0, "R5", d, 0);
    rd(2'd2, d); chk(d == 16'h0, "R6", d, 0);
    chk(!irq && !rx_drq && !tx_drq, "R4", {irq, rx_drq, tx_drq}, 0);

    // control mask, power-down keeps path off
    hw_en = 1;
    wr(2'd0, 16'hFFFF);
    rd(2'd0, d); chk(d == 16'h780F, "R13", d, 16'h780F);
    chk(irq == 1'b1, "R4", irq, 1);
    rx_send(16'h0055);
    rd(2'd2, d); chk(d == 16'h0, "R1", d, 0);

    // enable: bits 1, 11, 12, 14
    wr(2'd0, 16'h5802);
    rx_send(16'h1111);
    rx_send(16'h2222);
    @(negedge clk); chk(rx_drq == 1'b1, "R2", rx_drq, 1);
    tick();
    rd(2'd1, d); chk(d == 16'h0080, "R5", d, 16'h80);
    wr(2'd1, 16'h00FF);
    rd(2'd1, d); chk(d == 16'h00DF, "R5", d, 16'hDF);
    wr(2'd2, 16'hBEEF);
    rd(2'd2, d); chk(d == 16'h1111, "R9", d, 16'h1111);
    rd(2'd2, d); chk(d == 16'h2222, "R6", d, 16'h2222);
    rd(2'd2, d); chk(d == 16'h0, "R6", d, 0);
    chk(rx_drq == 1'b0, "R2", rx_drq, 0);
    rd(2'd3, d); chk(d == 16'h0, "R9", d, 0);

    // transmit flush at downstream free space
    tx_free = CW'(4);
    tick();
    chk(tx_drq == 1'b1, "R3", tx_drq, 1);
    for (int k = 0; k < 4; k++) wr(2'd3, 16'hA1 + 16'(k));
    @(negedge clk);
    chk(tx_valid == 1'b1 && tx_data == 16'hA1, "R7", tx_data, 16'hA1);
    chk(tx_drq == 1'b0, "R3", tx_drq, 0);
    @(posedge clk); #2 tx_ready = 1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(tx_valid && tx_data == 16'hA1 + 16'(k), "R7", tx_data, 16'hA1 + k);
    end
    tick(); tx_ready = 0;
    tick();
    chk(tx_valid == 1'b0, "R7", tx_valid, 0);

    // discard at capacity with no downstream space
    tx_free = '0;
    for (int k = 0; k < DEPTH; k++) wr(2'd3, 16'(k));
    tick();
    chk(tx_valid == 1'b0, "R8", tx_valid, 0);
    tx_free = CW'(2);
    tick();
    chk(tx_drq == 1'b1, "R8", tx_drq, 1);

    // simultaneous push and pop
    rx_send(16'h31); rx_send(16'h32); rx_send(16'h33);
    rx_valid = 1; rx_data = 16'h34;
    rd(2'd2, d); chk(d == 16'h31, "R10", d, 16'h31);
    rx_valid = 0;
    rd(2'd2, d); chk(d == 16'h32, "R10", d, 16'h32);
    rd(2'd2, d); chk(d == 16'h33, "R10", d, 16'h33);
    rd(2'd2, d); chk(d == 16'h34, "R10", d, 16'h34);
    rd(2'd2, d); chk(d == 16'h0, "R10", d, 0);

    // overflow
    for (int k = 0; k <= DEPTH; k++) rx_send(16'(k + 16'h100));
    tick();
    chk(rx_ovf == 1'b1, "R12", rx_ovf, 1);
    rd(2'd2, d); chk(d == 16'h100, "R12", d, 16'h100);
    chk(rx_ovf == 1'b1, "R12", rx_ovf, 1);

    // disable clears everything
    hw_en = 0;
    tick();
    chk(rx_ovf == 1'b0 && rx_drq == 1'b0, "R11", {rx_ovf, rx_drq}, 0);
    rx_send(16'h77);
    hw_en = 1;
    tick();
    rd(2'd2, d); chk(d == 16'h0, "R11", d, 0);
    rd(2'd2, d); chk(d == 16'h0, "R1", d, 0);

    repeat (3) tick();
    finish_run();
  end
endmodule